// File: doc/BRIEF.md
# SDRAM Command Encoder with Bank State Tracking

This block sits between a memory scheduler and the SDRAM pins. Each clock it takes at most one request: idle, load mode word, open a row, read, write, close rows, auto refresh or self refresh. It turns that request into the active-low select, row-strobe, column-strobe and write-enable pattern, together with clock-enable, bank address and the multiplexed address bus. All pin outputs are registered, so a request sampled at one rising edge appears on the pins for the cycle that follows.

The block keeps one open/idle bit for each internal bank. It refuses any request that would address a bank in the wrong state, or a bank that the current configuration does not have. A refused request drives deselect and raises a one-cycle error strobe. The block also holds the programmed read latency and raises a read-data-valid pulse at the right cycle after every issued read, even when reads are issued back to back.

Top module: `sdcmd_encoder`

## Requirements
- R1: Request codes on `req_op` are 0 idle, 1 mode load, 2 activate, 3 read, 4 write, 5 precharge, 6 auto refresh, 7 self refresh. An accepted request drives {cs_n,ras_n,cas_n,we_n} one cycle after the sampling edge: activate 0011, read 0101, write 0100, precharge 0010, both refresh kinds 0001, mode load 0000.
- R2: After reset, and for an idle code or no valid request, the block drives deselect (cs_n high) with clock-enable high and no error. Reset leaves all banks idle and the stored latency at 2.
- R3: A mode load drives bank address 00 and an address word of bits[12:7]=0, bits[6:4]=requested latency, bit 3=1 and bits[2:0]=001. The requested latency becomes the stored latency.
- R4: A mode load with latency 000 is refused. It drives deselect, pulses the error strobe, and leaves the stored latency unchanged.
- R5: `rd_valid` is high exactly N cycles after the cycle in which a read shows on the pins, where N is the stored latency (1 to 7). Back-to-back reads produce back-to-back pulses.
- R6: An activate marks its bank open. A read or write to an idle bank is refused: the block drives deselect, pulses the error strobe, and leaves the bank states unchanged.
- R7: An activate to a bank that already has an open row is refused with deselect and the error strobe.
- R8: A precharge with address bit 10 low closes only the bank on the bank address. With bit 10 high it closes all banks.
- R9: A read or write passes the bank onto the bank address and the column onto the address bus, with bit 10 forced low.
- R10: Auto refresh keeps clock-enable high. Self refresh drives clock-enable low, and it stays low until the next valid request. That request only raises clock-enable again: the pins show deselect, no error is raised and the request is not executed.
- R11: With `four_bank` low, only banks 0 and 1 exist. An activate, read, write or single-bank precharge to bank 2 or 3 is refused with the error strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| four_bank | input | 1 | 1: four banks, 0: two banks |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 3 | Request code (see R1) |
| req_bank | input | 2 | Target bank |
| req_addr | input | 13 | Row, column or precharge scope bit 10 |
| req_cas | input | 3 | Latency for a mode load |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_cke | output | 1 | Clock enable |
| sd_ba | output | 2 | Bank address |
| sd_addr | output | 13 | Multiplexed address |
| rd_valid | output | 1 | First read data valid this cycle |
| cmd_err | output | 1 | Request refused this cycle |
| bank_open | output | 4 | One bit per bank, 1 = row open |
| cas_lat | output | 3 | Stored read latency |

## Verification
The hardest cases to reach are overlapping read-valid pulses and the self-refresh exit. Pulses only overlap when reads follow each other on consecutive edges, so the bench issues them without an idle cycle between. It checks every cycle of the window at the shortest latency, and one long window at the largest latency. For the exit, the bench lets clock-enable sit low for several idle cycles. It then sends an activate that would be legal, and checks that the bank stays closed and that the pins only show deselect with clock-enable raised again.

// File: rtl/sdcmd_pkg.sv
package sdcmd_pkg;

   typedef enum logic [2:0] {
      OP_NOP  = 3'd0,
      OP_MODE = 3'd1,
      OP_ACT  = 3'd2,
      OP_RD   = 3'd3,
      OP_WR   = 3'd4,
      OP_PRE  = 3'd5,
      OP_AREF = 3'd6,
      OP_SREF = 3'd7
   } sd_op_e;

   typedef struct packed {
      logic cs_n;
      logic ras_n;
      logic cas_n;
      logic we_n;
   } sd_pins_t;

   localparam sd_pins_t PINS_DESL = 4'b1111;
   localparam sd_pins_t PINS_MODE = 4'b0000;
   localparam sd_pins_t PINS_PRE  = 4'b0010;
   localparam sd_pins_t PINS_ACT  = 4'b0011;
   localparam sd_pins_t PINS_WR   = 4'b0100;
   localparam sd_pins_t PINS_RD   = 4'b0101;
   localparam sd_pins_t PINS_REF  = 4'b0001;

   function automatic sd_pins_t pins_for(input sd_op_e op);
      sd_pins_t p;
      case (op)
         OP_MODE:         p = PINS_MODE;
         OP_ACT:          p = PINS_ACT;
         OP_RD:           p = PINS_RD;
         OP_WR:           p = PINS_WR;
         OP_PRE:          p = PINS_PRE;
         OP_AREF, OP_SREF: p = PINS_REF;
         default:         p = PINS_DESL;
      endcase
      return p;
   endfunction

endpackage

// File: rtl/sdcmd_bank_tracker.sv
module sdcmd_bank_tracker
   import sdcmd_pkg::*;
#(
   parameter int BA_W   = 2,
   parameter int AP_BIT = 10
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 four_bank,
   input  logic                 go,
   input  sd_op_e               op,
   input  logic [BA_W-1:0]      bank,
   input  logic                 ap,
   output logic                 legal,
   output logic [(1<<BA_W)-1:0] open_q
);
   localparam int NB = 1 << BA_W;

   generate
      if (BA_W < 1) begin : g_bad_ba
         $error("sdcmd_bank_tracker: BA_W must be at least 1");
      end
   endgenerate

   logic bank_ok;
   logic hit;

   always_comb begin
      bank_ok = four_bank || (bank[BA_W-1] == 1'b0);
      hit     = open_q[bank];
      case (op)
         OP_ACT:        legal = bank_ok && !hit;
         OP_RD, OP_WR:  legal = bank_ok && hit;
         OP_PRE:        legal = ap || bank_ok;
         default:       legal = 1'b1;
      endcase
   end

   generate
      for (genvar b = 0; b < NB; b++) begin : g_bank
         logic nxt;
         always_comb begin
            nxt = open_q[b];
            if (go && legal) begin
               if (op == OP_ACT && bank == BA_W'(b))
                  nxt = 1'b1;
               else if (op == OP_PRE && (ap || bank == BA_W'(b)))
                  nxt = 1'b0;
            end
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) open_q[b] <= 1'b0;
            else        open_q[b] <= nxt;
         end

         // R6: a bank only becomes open through an accepted activate to it
         p_open_by_act_r6: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(open_q[b]) |-> $past(go && op == OP_ACT && bank == BA_W'(b)));

         // R8: a bank only closes through a precharge
         p_close_by_pre_r8: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(open_q[b]) |-> $past(go && op == OP_PRE));
      end
   endgenerate

endmodule

// File: rtl/sdcmd_rd_pipe.sv
module sdcmd_rd_pipe #(
   parameter int CL_W = 3
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            fire,
   input  logic [CL_W-1:0] lat,
   output logic            rd_valid
);
   localparam int DEPTH = 1 << CL_W;

   generate
      if (CL_W < 1 || CL_W > 4) begin : g_bad_cl
         $error("sdcmd_rd_pipe: CL_W out of range");
      end
   endgenerate

   logic [DEPTH-1:0] sh_q;
   logic [DEPTH-1:0] sh_d;

   always_comb begin
      sh_d = {1'b0, sh_q[DEPTH-1:1]};
      if (fire) sh_d = sh_d | (DEPTH'(1) << lat);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh_q <= '0;
      else        sh_q <= sh_d;
   end

   assign rd_valid = sh_q[0];

   // R4: a read is never issued with the reserved latency
   p_lat_nonzero_r4: assert property (@(posedge clk) disable iff (!rst_n)
      fire |-> lat != '0);

endmodule

// File: rtl/sdcmd_encoder.sv
module sdcmd_encoder
   import sdcmd_pkg::*;
#(
   parameter int ADDR_W = 13,
   parameter int BA_W   = 2,
   parameter int CL_W   = 3,
   parameter int AP_BIT = 10,
   parameter int CL_RST = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 four_bank,
   input  logic                 req_valid,
   input  sd_op_e               req_op,
   input  logic [BA_W-1:0]      req_bank,
   input  logic [ADDR_W-1:0]    req_addr,
   input  logic [CL_W-1:0]      req_cas,
   output logic                 sd_cs_n,
   output logic                 sd_ras_n,
   output logic                 sd_cas_n,
   output logic                 sd_we_n,
   output logic                 sd_cke,
   output logic [BA_W-1:0]      sd_ba,
   output logic [ADDR_W-1:0]    sd_addr,
   output logic                 rd_valid,
   output logic                 cmd_err,
   output logic [(1<<BA_W)-1:0] bank_open,
   output logic [CL_W-1:0]      cas_lat
);
   localparam int MODE_LO_W = 4 + CL_W;
   localparam logic [3:0] MODE_LO = 4'b1001;

   generate
      if (ADDR_W < MODE_LO_W || ADDR_W <= AP_BIT) begin : g_bad_addr
         $error("sdcmd_encoder: ADDR_W too narrow");
      end
      if (CL_RST < 1 || CL_RST >= (1 << CL_W)) begin : g_bad_clrst
         $error("sdcmd_encoder: CL_RST out of range");
      end
   endgenerate

   sd_pins_t              pins_q, pins_d;
   logic                  cke_q, cke_d;
   logic                  sr_q, sr_d;
   logic                  err_d;
   logic [BA_W-1:0]       ba_d;
   logic [ADDR_W-1:0]     addr_d;
   logic [CL_W-1:0]       cl_d;
   logic                  go, legal, mode_bad, accept, rd_fire;

   assign go       = req_valid && !sr_q;
   assign mode_bad = (req_op == OP_MODE) && (req_cas == '0);
   assign accept   = go && legal && !mode_bad;
   assign rd_fire  = accept && (req_op == OP_RD);

   sdcmd_bank_tracker #(.BA_W(BA_W), .AP_BIT(AP_BIT)) bank_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .four_bank (four_bank),
      .go        (go && !mode_bad),
      .op        (req_op),
      .bank      (req_bank),
      .ap        (req_addr[AP_BIT]),
      .legal     (legal),
      .open_q    (bank_open)
   );

   sdcmd_rd_pipe #(.CL_W(CL_W)) pipe_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .fire     (rd_fire),
      .lat      (cas_lat),
      .rd_valid (rd_valid)
   );

   always_comb begin
      pins_d = accept ? pins_for(req_op) : PINS_DESL;
      err_d  = go && (!legal || mode_bad);
      ba_d   = '0;
      addr_d = '0;
      cl_d   = cas_lat;
      cke_d  = cke_q;
      sr_d   = sr_q;
      if (sr_q) begin
         if (req_valid) begin
            sr_d  = 1'b0;
            cke_d = 1'b1;
         end
      end else if (accept) begin
         case (req_op)
            OP_MODE: begin
               addr_d = {{(ADDR_W-MODE_LO_W){1'b0}}, req_cas, MODE_LO};
               cl_d   = req_cas;
            end
            OP_ACT, OP_PRE: begin
               ba_d   = req_bank;
               addr_d = req_addr;
            end
            OP_RD, OP_WR: begin
               ba_d           = req_bank;
               addr_d         = req_addr;
               addr_d[AP_BIT] = 1'b0;
            end
            OP_SREF: begin
               sr_d  = 1'b1;
               cke_d = 1'b0;
            end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pins_q  <= PINS_DESL;
         cke_q   <= 1'b1;
         sr_q    <= 1'b0;
         cmd_err <= 1'b0;
         sd_ba   <= '0;
         sd_addr <= '0;
         cas_lat <= CL_W'(CL_RST);
      end else begin
         pins_q  <= pins_d;
         cke_q   <= cke_d;
         sr_q    <= sr_d;
         cmd_err <= err_d;
         sd_ba   <= ba_d;
         sd_addr <= addr_d;
         cas_lat <= cl_d;
      end
   end

   assign sd_cs_n  = pins_q.cs_n;
   assign sd_ras_n = pins_q.ras_n;
   assign sd_cas_n = pins_q.cas_n;
   assign sd_we_n  = pins_q.we_n;
   assign sd_cke   = cke_q;

   // R6: a refused request leaves the device deselected
   p_err_desel_r6: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_err |-> sd_cs_n);

   // R3: the mode word on the pins matches the stored latency and fixed fields
   p_mode_word_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (pins_q == PINS_MODE) |-> (sd_ba == '0 && sd_addr[3:0] == MODE_LO
                                  && sd_addr[MODE_LO_W-1:4] == cas_lat));

   // R4: the stored latency never holds the reserved value
   p_cl_legal_r4: assert property (@(posedge clk) disable iff (!rst_n)
      cas_lat != '0);

   // R9: column accesses only reach an open bank, without auto precharge
   p_col_open_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (pins_q == PINS_RD || pins_q == PINS_WR) |-> (bank_open[sd_ba] && !sd_addr[AP_BIT]));

   // R8: an all-bank precharge leaves every bank idle
   p_prea_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (pins_q == PINS_PRE && sd_addr[AP_BIT]) |-> bank_open == '0);

   // R10: clock-enable drops only with a refresh pattern, returns only with deselect
   p_cke_fall_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sd_cke) |-> pins_q == PINS_REF);
   p_cke_rise_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sd_cke) |-> sd_cs_n);

   // R11: in two-bank mode no activate reaches an upper bank
   p_two_bank_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (!four_bank && $stable(four_bank) && pins_q == PINS_ACT) |-> !sd_ba[BA_W-1]);

endmodule

// File: tb/sdcmd_encoder_tb_top.sv
module sdcmd_encoder_tb_top;
   import sdcmd_pkg::*;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        four_bank = 1'b1;
   logic        req_valid = 1'b0;
   sd_op_e      req_op = OP_NOP;
   logic [1:0]  req_bank = '0;
   logic [12:0] req_addr = '0;
   logic [2:0]  req_cas = '0;
   logic        sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_cke;
   logic [1:0]  sd_ba;
   logic [12:0] sd_addr;
   logic        rd_valid, cmd_err;
   logic [3:0]  bank_open;
   logic [2:0]  cas_lat;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 0;

   always #5 clk = ~clk;

   sdcmd_encoder dut_i (
      .clk(clk), .rst_n(rst_n), .four_bank(four_bank),
      .req_valid(req_valid), .req_op(req_op), .req_bank(req_bank),
      .req_addr(req_addr), .req_cas(req_cas),
      .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n),
      .sd_we_n(sd_we_n), .sd_cke(sd_cke), .sd_ba(sd_ba), .sd_addr(sd_addr),
      .rd_valid(rd_valid), .cmd_err(cmd_err), .bank_open(bank_open),
      .cas_lat(cas_lat)
   );

   function automatic logic [3:0] pins();
      return {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic send(input sd_op_e op, input logic [1:0] b,
                       input logic [12:0] a, input logic [2:0] c);
      req_valid = 1'b1; req_op = op; req_bank = b; req_addr = a; req_cas = c;
      @(posedge clk); #1;
      req_valid = 1'b0; req_op = OP_NOP;
   endtask

   task automatic idle_cycle();
      @(posedge clk); #1;
   endtask

   task automatic t_reset();
      chk("R2 reset cs_n", sd_cs_n, 1);
      chk("R2 reset cke", sd_cke, 1);
      chk("R2 reset banks", bank_open, 0);
      chk("R2 reset latency", cas_lat, 2);
      chk("R2 reset rd_valid", rd_valid, 0);
      send(OP_NOP, 2'd1, 13'h1FFF, 3'd5);
      chk("R2 idle code cs_n", sd_cs_n, 1);
      chk("R2 idle code err", cmd_err, 0);
   endtask

   task automatic t_mode();
      send(OP_MODE, 2'd3, 13'h1FFF, 3'd3);
      chk("R1 mode pins", pins(), 4'b0000);
      chk("R3 mode ba", sd_ba, 0);
      chk("R3 mode word", sd_addr, 13'h039);
      chk("R3 latency stored", cas_lat, 3);
      send(OP_MODE, 2'd0, 13'h0, 3'd0);
      chk("R4 reserved cs_n", sd_cs_n, 1);
      chk("R4 reserved err", cmd_err, 1);
      chk("R4 latency kept", cas_lat, 3);
      idle_cycle();
      chk("R4 err one cycle", cmd_err, 0);
   endtask

   task automatic t_act_rw();
      send(OP_ACT, 2'd1, 13'h1ABC, 3'd0);
      chk("R1 act pins", pins(), 4'b0011);
      chk("R6 act ba", sd_ba, 1);
      chk("R6 act row", sd_addr, 13'h1ABC);
      chk("R6 bank opened", bank_open, 4'b0010);
      send(OP_RD, 2'd1, 13'h05FF, 3'd0);
      chk("R1 read pins", pins(), 4'b0101);
      chk("R9 read column bit10 low", sd_addr, 13'h01FF);
      chk("R9 read ba", sd_ba, 1);
      chk("R5 cl3 no early", rd_valid, 0);
      for (int i = 1; i <= 4; i++) begin
         idle_cycle();
         chk($sformatf("R5 cl3 cycle %0d", i), rd_valid, (i == 3));
      end
      send(OP_WR, 2'd1, 13'h047A, 3'd0);
      chk("R1 write pins", pins(), 4'b0100);
      chk("R9 write column", sd_addr, 13'h007A);
   endtask

   task automatic t_b2b();
      send(OP_MODE, 2'd0, 13'h0, 3'd2);
      chk("R3 latency 2", cas_lat, 2);
      send(OP_RD, 2'd1, 13'h0010, 3'd0);
      send(OP_RD, 2'd1, 13'h0012, 3'd0);
      chk("R5 b2b c1", rd_valid, 0);
      idle_cycle(); chk("R5 b2b first pulse", rd_valid, 1);
      idle_cycle(); chk("R5 b2b second pulse", rd_valid, 1);
      idle_cycle(); chk("R5 b2b end", rd_valid, 0);
      send(OP_MODE, 2'd0, 13'h0, 3'd7);
      send(OP_RD, 2'd1, 13'h0020, 3'd0);
      for (int i = 1; i <= 8; i++) begin
         idle_cycle();
         chk($sformatf("R5 cl7 cycle %0d", i), rd_valid, (i == 7));
      end
      send(OP_MODE, 2'd0, 13'h0, 3'd1);
      send(OP_RD, 2'd1, 13'h0020, 3'd0);
      idle_cycle(); chk("R5 cl1 pulse", rd_valid, 1);
      idle_cycle(); chk("R5 cl1 end", rd_valid, 0);
   endtask

   task automatic t_illegal();
      send(OP_RD, 2'd2, 13'h0001, 3'd0);
      chk("R6 read idle cs_n", sd_cs_n, 1);
      chk("R6 read idle err", cmd_err, 1);
      chk("R6 read idle banks", bank_open, 4'b0010);
      idle_cycle(); chk("R6 no read pulse", rd_valid, 0);
      send(OP_WR, 2'd0, 13'h0001, 3'd0);
      chk("R6 write idle err", cmd_err, 1);
      chk("R6 write idle cs_n", sd_cs_n, 1);
      send(OP_ACT, 2'd1, 13'h0777, 3'd0);
      chk("R7 act open err", cmd_err, 1);
      chk("R7 act open cs_n", sd_cs_n, 1);
      chk("R7 banks kept", bank_open, 4'b0010);
   endtask

   task automatic t_pre();
      send(OP_ACT, 2'd3, 13'h0100, 3'd0);
      chk("R6 bank3 open", bank_open, 4'b1010);
      send(OP_PRE, 2'd1, 13'h0000, 3'd0);
      chk("R1 pre pins", pins(), 4'b0010);
      chk("R8 single close", bank_open, 4'b1000);
      send(OP_ACT, 2'd0, 13'h0200, 3'd0);
      chk("R8 reopen bank0", bank_open, 4'b1001);
      send(OP_PRE, 2'd2, 13'h0400, 3'd0);
      chk("R8 all close", bank_open, 4'b0000);
      chk("R8 all bit10", sd_addr[10], 1);
   endtask

   task automatic t_refresh();
      send(OP_AREF, 2'd0, 13'h0, 3'd0);
      chk("R1 auto refresh pins", pins(), 4'b0001);
      chk("R10 auto cke", sd_cke, 1);
      send(OP_SREF, 2'd0, 13'h0, 3'd0);
      chk("R10 self pins", pins(), 4'b0001);
      chk("R10 self cke", sd_cke, 0);
      idle_cycle();
      idle_cycle();
      chk("R10 cke held low", sd_cke, 0);
      chk("R10 held deselect", sd_cs_n, 1);
      send(OP_ACT, 2'd0, 13'h0042, 3'd0);
      chk("R10 exit cke", sd_cke, 1);
      chk("R10 exit deselect", sd_cs_n, 1);
      chk("R10 exit no err", cmd_err, 0);
      chk("R10 exit not executed", bank_open, 0);
      send(OP_ACT, 2'd0, 13'h0042, 3'd0);
      chk("R10 after exit act", bank_open, 4'b0001);
      send(OP_PRE, 2'd0, 13'h0400, 3'd0);
   endtask

   task automatic t_two_bank();
      four_bank = 1'b0;
      idle_cycle();
      send(OP_ACT, 2'd2, 13'h0011, 3'd0);
      chk("R11 act bank2 err", cmd_err, 1);
      chk("R11 act bank2 cs_n", sd_cs_n, 1);
      chk("R11 banks idle", bank_open, 0);
      send(OP_ACT, 2'd1, 13'h0011, 3'd0);
      chk("R11 act bank1 ok", bank_open, 4'b0010);
      chk("R11 act bank1 no err", cmd_err, 0);
      send(OP_PRE, 2'd3, 13'h0000, 3'd0);
      chk("R11 pre bank3 err", cmd_err, 1);
      send(OP_RD, 2'd3, 13'h0000, 3'd0);
      chk("R11 read bank3 err", cmd_err, 1);
      send(OP_PRE, 2'd0, 13'h0400, 3'd0);
      chk("R11 all close", bank_open, 0);
      four_bank = 1'b1;
      idle_cycle();
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      t_reset();
      t_mode();
      t_act_rw();
      t_b2b();
      t_illegal();
      t_pre();
      t_refresh();
      t_two_bank();
      if (!done) begin
         done = 1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

endmodule